// File: doc/BRIEF.md
# Global-History Branch Direction and Target Predictor

This block gives an in-order fetch unit a guess, in the same cycle, of where fetch should go after the instruction at the current fetch address. It holds two storage structures. A direct-mapped branch target buffer remembers, per branch address, the target that branch last resolved to. A table of 2-bit saturating counters remembers how each branch tends to behave. The counter table is addressed by the fetch address mixed by exclusive-OR with a shift register of recent branch outcomes, so one branch can use different counters depending on the path that led to it. The target buffer is addressed by the fetch address alone.

The lookup side is purely combinational: the fetch address goes in and the hit flag, direction guess, stored target and next fetch address come out in the same cycle. The resolve side is registered: when a branch completes, the back end presents its address, its real direction and its real target. At that clock edge the counter, the target entry and the history register are all updated.

Top module: `bp_gshare_btb`

## Requirements
- R1: After synchronous reset every direction counter holds 1 (weakly not taken), every target entry is invalid and the history register is zero, so any lookup gives hit 0, taken 0 and next address = lookup address + 4.
- R2: A branch address that was never resolved misses. After a resolve at address P with target T, a lookup of P in a later cycle gives hit 1 and lk_target = T. The target entry is written on every resolve, whether taken or not.
- R3: The target buffer is direct-mapped with 64 entries. The entry index is address bits [7:2] and the tag is address bits [31:8]. An address with the same index but a different tag misses, and resolving it replaces the earlier entry.
- R4: Each counter is 2 bits. A taken outcome increments it and saturates at 3. A not-taken outcome decrements it and saturates at 0. The values 2 and 3 predict taken.
- R5: The counter table has 256 entries. It is indexed by address bits [9:2] XOR history bits [7:0]. The target buffer index does not use the history.
- R6: On a resolve, the counter that is updated is the one selected by the history as it stood before that resolve. In the same edge the history shifts left by one, with the outcome (1 = taken) entering bit 0.
- R7: Taken is predicted only when the lookup hits and the selected counter is 2 or 3. In that case the next address is the stored target. Otherwise it is the lookup address + 4.
- R8: When a resolve and a lookup name the same entries in the same cycle, the lookup returns the contents from before that resolve. The new contents show from the next cycle.
- R9: Without a resolve, the history register and all table contents are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | 32 | Fetch address to predict for |
| lk_hit | output | 1 | Target buffer holds an entry for lk_pc |
| lk_taken | output | 1 | Branch at lk_pc is predicted taken |
| lk_target | output | 32 | Stored target on a hit, zero on a miss |
| lk_next_pc | output | 32 | Predicted next fetch address |
| up_valid | input | 1 | A branch resolves this cycle |
| up_pc | input | 32 | Address of the resolving branch |
| up_taken | input | 1 | Actual direction, 1 = taken |
| up_target | input | 32 | Actual target of the resolving branch |

## Verification
A wrong counter value stays invisible until a lookup both hits and selects that counter. The bench therefore sets up history states in which a known address selects a counter trained under a different history, and a wrap instead of saturation flips the direction. A history register that shifts wrongly shows one resolve later, as predictions that disagree with a behavioural model of the tables. Target buffer faults show at once as wrong hit flags or targets for addresses that share an index. The same-cycle case is sampled both before and after the resolving edge.

// File: rtl/bp_pkg.sv
package bp_pkg;
    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_RESET = 2'd1;
    localparam ctr_t CTR_MAX   = 2'd3;
    localparam ctr_t CTR_MIN   = 2'd0;

    function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
        ctr_t n;
        if (taken) n = (c == CTR_MAX) ? c : c + 2'd1;
        else       n = (c == CTR_MIN) ? c : c - 2'd1;
        return n;
    endfunction

    function automatic logic ctr_says_taken(input ctr_t c);
        return c[1];
    endfunction
endpackage

// File: rtl/bp_hist_reg.sv
module bp_hist_reg #(
    parameter int HIST_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [HIST_W-1:0] hist_o
);
    logic [HIST_W-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst)           hist_q <= '0;
        else if (shift_en) hist_q <= {hist_q[HIST_W-2:0], bit_in};
    end

    assign hist_o = hist_q;
endmodule

// File: rtl/bp_dir_table.sv
module bp_dir_table
    import bp_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_t             rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    localparam int DEPTH = 1 << IDX_W;

    ctr_t ctr_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_RESET;
        end else if (wr_en) begin
            ctr_q[wr_idx] <= ctr_step(ctr_q[wr_idx], wr_taken);
        end
    end

    assign rd_ctr = ctr_q[rd_idx];
endmodule

// File: rtl/bp_target_buf.sv
module bp_target_buf #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:2] rd_word,
    output logic              rd_hit,
    output logic [ADDR_W-1:0] rd_target,
    input  logic              wr_en,
    input  logic [ADDR_W-1:2] wr_word,
    input  logic [ADDR_W-1:0] wr_target
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int TAG_W = ADDR_W - 2 - IDX_W;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] target;
    } entry_t;

    logic [DEPTH-1:0] valid_q;
    entry_t           ent_q [DEPTH];

    logic [IDX_W-1:0] rd_idx, wr_idx;
    logic [TAG_W-1:0] rd_tag, wr_tag;

    assign rd_idx = rd_word[IDX_W+1:2];
    assign rd_tag = rd_word[ADDR_W-1:IDX_W+2];
    assign wr_idx = wr_word[IDX_W+1:2];
    assign wr_tag = wr_word[ADDR_W-1:IDX_W+2];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) ent_q[wr_idx] <= '{tag: wr_tag, target: wr_target};
    end

    entry_t rd_ent;
    assign rd_ent    = ent_q[rd_idx];
    assign rd_hit    = valid_q[rd_idx] && (rd_ent.tag == rd_tag);
    assign rd_target = rd_hit ? rd_ent.target : '0;
endmodule

// File: rtl/bp_gshare_btb.sv
module bp_gshare_btb
    import bp_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int HIST_W    = 8,
    parameter int DIR_IDX_W = 8,
    parameter int BTB_IDX_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] lk_pc,
    output logic              lk_hit,
    output logic              lk_taken,
    output logic [ADDR_W-1:0] lk_target,
    output logic [ADDR_W-1:0] lk_next_pc,
    input  logic              up_valid,
    input  logic [ADDR_W-1:0] up_pc,
    input  logic              up_taken,
    input  logic [ADDR_W-1:0] up_target
);
    localparam logic [ADDR_W-1:0] INSN_BYTES = ADDR_W'(4);

    logic [HIST_W-1:0]    ghr;
    logic [DIR_IDX_W-1:0] hist_mix;
    logic [DIR_IDX_W-1:0] lk_dir_idx, up_dir_idx;
    ctr_t                 lk_ctr;
    logic                 unused_low_bits;

    assign unused_low_bits = ^up_pc[1:0];

    bp_hist_reg #(.HIST_W(HIST_W)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .shift_en (up_valid),
        .bit_in   (up_taken),
        .hist_o   (ghr)
    );

    generate
        if (HIST_W >= DIR_IDX_W) begin : g_hist_wide
            assign hist_mix = ghr[DIR_IDX_W-1:0];
        end else begin : g_hist_narrow
            assign hist_mix = {{(DIR_IDX_W-HIST_W){1'b0}}, ghr};
        end
    endgenerate

    assign lk_dir_idx = lk_pc[DIR_IDX_W+1:2] ^ hist_mix;
    assign up_dir_idx = up_pc[DIR_IDX_W+1:2] ^ hist_mix;

    bp_dir_table #(.IDX_W(DIR_IDX_W)) u_dir (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (lk_dir_idx),
        .rd_ctr   (lk_ctr),
        .wr_en    (up_valid),
        .wr_idx   (up_dir_idx),
        .wr_taken (up_taken)
    );

    bp_target_buf #(.ADDR_W(ADDR_W), .IDX_W(BTB_IDX_W)) u_btb (
        .clk       (clk),
        .rst       (rst),
        .rd_word   (lk_pc[ADDR_W-1:2]),
        .rd_hit    (lk_hit),
        .rd_target (lk_target),
        .wr_en     (up_valid),
        .wr_word   (up_pc[ADDR_W-1:2]),
        .wr_target (up_target)
    );

    assign lk_taken   = lk_hit && ctr_says_taken(lk_ctr);
    assign lk_next_pc = lk_taken ? lk_target : lk_pc + INSN_BYTES;
endmodule

// File: rtl/bp_gshare_btb_chk.sv
module bp_gshare_btb_chk #(
    parameter int ADDR_W = 32,
    parameter int HIST_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] lk_pc,
    input logic              lk_hit,
    input logic              lk_taken,
    input logic [ADDR_W-1:0] lk_target,
    input logic [ADDR_W-1:0] lk_next_pc,
    input logic              up_valid,
    input logic              up_taken,
    input logic [HIST_W-1:0] ghr
);
    // R7: a taken guess needs a target entry
    p_taken_needs_hit_r7: assert property (@(posedge clk) disable iff (rst)
        lk_taken |-> lk_hit);

    // R7: taken guess redirects to the stored target
    p_taken_target_r7: assert property (@(posedge clk) disable iff (rst)
        lk_taken |-> (lk_next_pc == lk_target));

    // R7: otherwise fetch falls through
    p_fallthru_r7: assert property (@(posedge clk) disable iff (rst)
        !lk_taken |-> (lk_next_pc == lk_pc + ADDR_W'(4)));

    // R6: history shifts in the outcome on a resolve
    p_hist_shift_r6: assert property (@(posedge clk) disable iff (rst)
        up_valid |=> (ghr == {$past(ghr[HIST_W-2:0]), $past(up_taken)}));

    // R9: history holds without a resolve
    p_hist_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !up_valid |=> $stable(ghr));
endmodule

bind bp_gshare_btb bp_gshare_btb_chk #(.ADDR_W(ADDR_W), .HIST_W(HIST_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .lk_pc      (lk_pc),
    .lk_hit     (lk_hit),
    .lk_taken   (lk_taken),
    .lk_target  (lk_target),
    .lk_next_pc (lk_next_pc),
    .up_valid   (up_valid),
    .up_taken   (up_taken),
    .ghr        (ghr)
);

// File: tb/bp_gshare_btb_tb.sv
module bp_gshare_btb_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] lk_pc;
    logic        lk_hit, lk_taken;
    logic [31:0] lk_target, lk_next_pc;
    logic        up_valid;
    logic [31:0] up_pc;
    logic        up_taken;
    logic [31:0] up_target;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    bp_gshare_btb u_dut (
        .clk(clk), .rst(rst),
        .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_taken(lk_taken),
        .lk_target(lk_target), .lk_next_pc(lk_next_pc),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
        .up_target(up_target)
    );

    // behavioural model built from the requirements
    logic [1:0]  m_ctr [256];
    logic        m_val [64];
    logic [23:0] m_tag [64];
    logic [31:0] m_tgt [64];
    logic [7:0]  m_hist;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; up_valid = 1'b0; up_pc = '0; up_taken = 1'b0;
        up_target = '0; lk_pc = '0;
        @(posedge clk); @(posedge clk);
        #1 rst = 1'b0;
        for (int i = 0; i < 256; i++) m_ctr[i] = 2'd1;
        for (int i = 0; i < 64; i++) begin
            m_val[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0;
        end
        m_hist = '0;
    endtask

    task automatic do_resolve(input logic [31:0] pc, input logic tk,
                              input logic [31:0] tg);
        logic [7:0] di;
        @(negedge clk);
        up_valid = 1'b1; up_pc = pc; up_taken = tk; up_target = tg;
        @(posedge clk);
        #1;
        di = pc[9:2] ^ m_hist;
        if (tk && m_ctr[di] != 2'd3) m_ctr[di] = m_ctr[di] + 2'd1;
        if (!tk && m_ctr[di] != 2'd0) m_ctr[di] = m_ctr[di] - 2'd1;
        m_val[pc[7:2]] = 1'b1; m_tag[pc[7:2]] = pc[31:8]; m_tgt[pc[7:2]] = tg;
        m_hist = {m_hist[6:0], tk};
        up_valid = 1'b0;
    endtask

    // hand-computed expectation
    task automatic look(input logic [31:0] pc, input logic e_hit, input logic e_tk,
                        input logic [31:0] e_next, input string req);
        @(negedge clk);
        lk_pc = pc;
        #2;
        chk(lk_hit == e_hit, req, 32'(lk_hit), 32'(e_hit));
        chk(lk_taken == e_tk, req, 32'(lk_taken), 32'(e_tk));
        chk(lk_next_pc == e_next, req, lk_next_pc, e_next);
    endtask

    // model expectation
    task automatic look_model(input logic [31:0] pc, input string req);
        logic h, t;
        logic [31:0] n;
        h = m_val[pc[7:2]] && (m_tag[pc[7:2]] == pc[31:8]);
        t = h && m_ctr[pc[9:2] ^ m_hist][1];
        n = t ? m_tgt[pc[7:2]] : pc + 32'd4;
        look(pc, h, t, n, req);
        chk(lk_target == (h ? m_tgt[pc[7:2]] : 32'd0), req, lk_target,
            h ? m_tgt[pc[7:2]] : 32'd0);
    endtask

    // {pc, taken, target}
    localparam logic [64:0] VEC [16] = '{
        {32'h0000_1000, 1'b1, 32'h0000_1800},
        {32'h0000_1004, 1'b0, 32'h0000_1900},
        {32'h0000_1000, 1'b1, 32'h0000_1800},
        {32'h0000_2000, 1'b1, 32'h0000_2400},
        {32'h0000_1000, 1'b1, 32'h0000_1800},
        {32'h0000_1008, 1'b1, 32'h0000_0f00},
        {32'h0000_1008, 1'b1, 32'h0000_0f00},
        {32'h0000_1004, 1'b0, 32'h0000_1900},
        {32'h0000_1008, 1'b1, 32'h0000_0f00},
        {32'h0000_1000, 1'b0, 32'h0000_1800},
        {32'h0000_2000, 1'b1, 32'h0000_2400},
        {32'h0000_2000, 1'b1, 32'h0000_2400},
        {32'h0000_1008, 1'b1, 32'h0000_0f00},
        {32'h0000_1008, 1'b1, 32'h0000_0f00},
        {32'h0000_1004, 1'b1, 32'h0000_1a00},
        {32'h0000_1008, 1'b1, 32'h0000_0f00}
    };

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%h expected=%h", 32'd0, 32'd1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; up_valid = 1'b0; up_pc = '0; up_taken = 1'b0;
        up_target = '0; lk_pc = '0;

        // R1: reset state
        do_reset();
        look(32'h0000_0100, 1'b0, 1'b0, 32'h0000_0104, "R1 reset miss");

        // R2 / R3: fill, tag compare, replacement
        look(32'h0000_0100, 1'b0, 1'b0, 32'h0000_0104, "R2 first sight miss");
        do_resolve(32'h0000_0100, 1'b0, 32'h0000_5000);
        look(32'h0000_0100, 1'b1, 1'b0, 32'h0000_0104, "R2 hit after fill");
        chk(lk_target == 32'h0000_5000, "R2 target", lk_target, 32'h0000_5000);
        look(32'h0000_0200, 1'b0, 1'b0, 32'h0000_0204, "R3 tag mismatch");
        do_resolve(32'h0000_0200, 1'b1, 32'h0000_6000);
        look(32'h0000_0100, 1'b0, 1'b0, 32'h0000_0104, "R3 replaced");
        look(32'h0000_0200, 1'b1, 1'b0, 32'h0000_0204, "R3 new owner");

        // R5 / R1: history-mixed index reaches a counter trained elsewhere
        do_reset();
        do_resolve(32'h0000_0104, 1'b0, 32'h0000_4000);
        do_resolve(32'h0000_0100, 1'b1, 32'h0000_5000);
        look(32'h0000_0104, 1'b1, 1'b1, 32'h0000_4000, "R5 R1 xor index taken");
        look(32'h0000_0100, 1'b1, 1'b0, 32'h0000_0104, "R5 R6 own counter low");
        repeat (5) @(posedge clk);
        look(32'h0000_0104, 1'b1, 1'b1, 32'h0000_4000, "R9 idle hold");

        // R4: saturation at 0
        do_reset();
        do_resolve(32'h0000_0104, 1'b0, 32'h0000_4000);
        repeat (3) do_resolve(32'h0000_0100, 1'b0, 32'h0000_5000);
        do_resolve(32'h0000_0100, 1'b1, 32'h0000_5000);
        look(32'h0000_0104, 1'b1, 1'b0, 32'h0000_0108, "R4 floor saturates");

        // R4: saturation at 3
        do_reset();
        repeat (12) do_resolve(32'h0000_0100, 1'b1, 32'h0000_5000);
        look(32'h0000_0100, 1'b1, 1'b1, 32'h0000_5000, "R4 ceiling saturates");

        // R8: same-cycle resolve and lookup
        do_reset();
        @(negedge clk);
        lk_pc = 32'h0000_0300;
        up_valid = 1'b1; up_pc = 32'h0000_0300; up_taken = 1'b1;
        up_target = 32'h0000_7000;
        #2 chk(lk_hit == 1'b0, "R8 old contents", 32'(lk_hit), 32'd0);
        @(posedge clk);
        #1 up_valid = 1'b0;
        #1 chk(lk_hit == 1'b1, "R8 new next cycle", 32'(lk_hit), 32'd1);
        chk(lk_target == 32'h0000_7000, "R8 target", lk_target, 32'h0000_7000);

        // R2 R4 R5 R6 R7: vector walk against the model
        do_reset();
        foreach (VEC[i]) begin
            look_model(VEC[i][64:33], "R7 R6 vector lookup");
            do_resolve(VEC[i][64:33], VEC[i][32], VEC[i][31:0]);
        end
        foreach (VEC[i]) look_model(VEC[i][64:33], "R5 R2 vector final");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule